// File: doc/BRIEF.md
# Edge-Change Interrupt Controller

This block watches a bank of digital input channels and raises one active-high interrupt when any selected channel shows a selected transition. Every channel passes through a synchroniser, and its synchronised sample is compared with the sample one cycle older. That comparison produces a one-cycle rising or a falling event. Each group of eight channels has a rising-enable byte and a falling-enable byte. The control register holds two global gates, one for rising detection and one for falling detection, so software can arm a whole direction at once.

Events are recorded in a small state machine with four named states. ST_QUIET means no flag is set. ST_EDGE means the edge flag is set. ST_EDGE_OVF means both the edge and the overflow flags are set. ST_OVF means only the overflow flag is set. A qualifying event moves ST_QUIET to ST_EDGE. A further event while the edge flag is held moves the machine to ST_EDGE_OVF. Writes to the acknowledge register drop the machine back through ST_EDGE, ST_OVF or ST_QUIET, depending on which flags are cleared.

An event that arrives in the same cycle as an acknowledge of the edge flag re-arms that flag. In that case no overflow is recorded. The interrupt is the master enable ANDed with the OR of each flag gated by its own enable. The host reaches the block through a byte-wide register port. Writes happen on the strobe, and read data is combinational on the address.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, all rising and falling masks read 0x00, control reads 0x00, status reads 0x00, and `irq` is low.
- R2: Address 0x06 always reads 0x27, and a write to it changes nothing.
- R3: The rising-mask byte for group g is at 0x18+g, and the falling-mask byte for group g is at 0x20+g. Both are read/write. Bit b of byte g selects channel 8g+b.
- R4: With control bit 3 (rising gate) set, a 0-to-1 transition on a channel whose rising mask bit is set sets status bit 0 (edge flag). The flag is visible three clock edges after the input changes.
- R5: With control bit 4 (falling gate) set, a 1-to-0 transition on a channel whose falling mask bit is set sets status bit 0.
- R6: A transition on a channel whose mask bit is clear, or in a direction whose global gate is clear, leaves the status unchanged.
- R7: A qualifying transition while status bit 0 is already set sets status bit 1 (overflow), and status bit 0 stays set.
- R8: A write to 0x07 clears status bit 0 when data bit 3 is 1 and clears status bit 1 when data bit 2 is 1. Both may be cleared in one write, and other data bits have no effect.
- R9: `irq` and status bit 2 equal control bit 2 (master enable) AND ((status bit 0 AND control bit 0) OR (status bit 1 AND control bit 1)).
- R10: The flags record events while the interrupt enables are off. Writing 0x00 to control drops `irq` and keeps the flags.
- R11: A qualifying transition in the same cycle as a write that clears status bit 0 leaves status bit 0 set and does not set status bit 1.
- R12: Control at 0x15 reads back data bits 4:0, and bits 7:5 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_in | input | NUM_GROUPS*8 | Asynchronous digital input channels |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Active-high interrupt |

## Verification
A register write takes effect at the clock edge that samples the strobe. Its effect on read data and on `irq` is visible at the following falling edge. A change on `chan_in` passes two synchroniser stages and then the state register, so the flags and `irq` are due three rising edges after the input change. The bench drives every input at a falling edge and waits exactly three falling edges after an input change before it queues the expected status. The same-cycle collision in R11 is built by asserting the acknowledge write in the cycle where the synchronised event is present, so that both reach the state register at the same edge.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

    localparam int unsigned REG_AW = 8;
    localparam int unsigned REG_DW = 8;
    localparam int unsigned GRP_W  = 8;

    localparam logic [REG_AW-1:0] OFS_ID    = 8'h06;
    localparam logic [REG_AW-1:0] OFS_ACK   = 8'h07;
    localparam logic [REG_AW-1:0] OFS_STAT  = 8'h14;
    localparam logic [REG_AW-1:0] OFS_CTRL  = 8'h15;
    localparam logic [REG_AW-1:0] OFS_RMASK = 8'h18;
    localparam logic [REG_AW-1:0] OFS_FMASK = 8'h20;

    localparam logic [REG_DW-1:0] ID_VALUE = 8'h27;

    localparam int unsigned ACK_EDGE_BIT = 3;
    localparam int unsigned ACK_OVF_BIT  = 2;

    // control byte, bit 4 down to bit 0
    typedef struct packed {
        logic fall_en;
        logic rise_en;
        logic master_ie;
        logic ovf_ie;
        logic edge_ie;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    // bit 0 = edge flag, bit 1 = overflow flag
    typedef enum logic [1:0] {
        ST_QUIET    = 2'b00,
        ST_EDGE     = 2'b01,
        ST_OVF      = 2'b10,
        ST_EDGE_OVF = 2'b11
    } ev_state_e;

endpackage

// File: rtl/edge_irq_sampler.sv
module edge_irq_sampler
    import edge_irq_pkg::*;
#(
    parameter int unsigned NUM_CH      = 24,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] chan_in,
    output logic [NUM_CH-1:0] rise,
    output logic [NUM_CH-1:0] fall
);

    localparam int unsigned LAST = SYNC_STAGES - 1;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [SYNC_STAGES-1:0] pipe_q;
        logic                   prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe_q <= '0;
                prev_q <= 1'b0;
            end else begin
                pipe_q[0] <= chan_in[c];
                for (int k = 1; k < SYNC_STAGES; k++) begin
                    pipe_q[k] <= pipe_q[k-1];
                end
                prev_q <= pipe_q[LAST];
            end
        end

        assign rise[c] =  pipe_q[LAST] & ~prev_q;
        assign fall[c] = ~pipe_q[LAST] &  prev_q;
    end

endmodule

// File: rtl/edge_irq_regs.sv
module edge_irq_regs
    import edge_irq_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 3,
    localparam int unsigned NUM_CH    = NUM_GROUPS * GRP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_DW-1:0] reg_wdata,
    input  logic [REG_DW-1:0] status_byte,
    output ctrl_t             ctrl_q,
    output logic [NUM_CH-1:0] rmask,
    output logic [NUM_CH-1:0] fmask,
    output logic              ack_edge,
    output logic              ack_ovf,
    output logic [REG_DW-1:0] reg_rdata
);

    logic [GRP_W-1:0] rmask_q [NUM_GROUPS];
    logic [GRP_W-1:0] fmask_q [NUM_GROUPS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (reg_wr && reg_addr == OFS_CTRL) begin
            ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < NUM_GROUPS; g++) begin
                rmask_q[g] <= '0;
                fmask_q[g] <= '0;
            end
        end else if (reg_wr) begin
            for (int g = 0; g < NUM_GROUPS; g++) begin
                if (reg_addr == OFS_RMASK + REG_AW'(g)) rmask_q[g] <= reg_wdata;
                if (reg_addr == OFS_FMASK + REG_AW'(g)) fmask_q[g] <= reg_wdata;
            end
        end
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_flat
        assign rmask[g*GRP_W +: GRP_W] = rmask_q[g];
        assign fmask[g*GRP_W +: GRP_W] = fmask_q[g];
    end

    assign ack_edge = reg_wr && (reg_addr == OFS_ACK) && reg_wdata[ACK_EDGE_BIT];
    assign ack_ovf  = reg_wr && (reg_addr == OFS_ACK) && reg_wdata[ACK_OVF_BIT];

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_ID) begin
            reg_rdata = ID_VALUE;
        end else if (reg_addr == OFS_CTRL) begin
            reg_rdata = {{(REG_DW-CTRL_W){1'b0}}, ctrl_q};
        end else if (reg_addr == OFS_STAT) begin
            reg_rdata = status_byte;
        end
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (reg_addr == OFS_RMASK + REG_AW'(g)) reg_rdata = rmask_q[g];
            if (reg_addr == OFS_FMASK + REG_AW'(g)) reg_rdata = fmask_q[g];
        end
    end

endmodule

// File: rtl/edge_irq_fsm.sv
module edge_irq_fsm
    import edge_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic ack_edge,
    input  logic ack_ovf,
    output logic edge_flag,
    output logic ovf_flag
);

    ev_state_e state_q;
    ev_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: begin
                if (hit) state_d = ST_EDGE;
            end
            ST_EDGE: begin
                if (hit && !ack_edge)      state_d = ST_EDGE_OVF;
                else if (hit)              state_d = ST_EDGE;
                else if (ack_edge)         state_d = ST_QUIET;
            end
            ST_EDGE_OVF: begin
                if (hit && !ack_edge)      state_d = ST_EDGE_OVF;
                else if (hit)              state_d = ack_ovf ? ST_EDGE : ST_EDGE_OVF;
                else if (ack_edge)         state_d = ack_ovf ? ST_QUIET : ST_OVF;
                else if (ack_ovf)          state_d = ST_EDGE;
            end
            ST_OVF: begin
                if (hit)                   state_d = ack_ovf ? ST_EDGE : ST_EDGE_OVF;
                else if (ack_ovf)          state_d = ST_QUIET;
            end
            default: state_d = ST_QUIET;
        endcase
    end

    always_comb begin
        edge_flag = 1'b0;
        ovf_flag  = 1'b0;
        unique case (state_q)
            ST_QUIET:    ;
            ST_EDGE:     edge_flag = 1'b1;
            ST_OVF:      ovf_flag  = 1'b1;
            ST_EDGE_OVF: begin
                edge_flag = 1'b1;
                ovf_flag  = 1'b1;
            end
            default:     ;
        endcase
    end

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
    import edge_irq_pkg::*;
#(
    parameter int unsigned NUM_GROUPS  = 3,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned NUM_CH     = NUM_GROUPS * GRP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] chan_in,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              irq
);

    logic [NUM_CH-1:0] rise;
    logic [NUM_CH-1:0] fall;
    logic [NUM_CH-1:0] rmask;
    logic [NUM_CH-1:0] fmask;
    ctrl_t             ctrl_q;
    logic              ack_edge;
    logic              ack_ovf;
    logic              edge_flag;
    logic              ovf_flag;
    logic              hit;
    logic [REG_DW-1:0] status_byte;

    edge_irq_sampler #(
        .NUM_CH      (NUM_CH),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .chan_in (chan_in),
        .rise    (rise),
        .fall    (fall)
    );

    edge_irq_regs #(
        .NUM_GROUPS (NUM_GROUPS)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_addr    (reg_addr),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .status_byte (status_byte),
        .ctrl_q      (ctrl_q),
        .rmask       (rmask),
        .fmask       (fmask),
        .ack_edge    (ack_edge),
        .ack_ovf     (ack_ovf),
        .reg_rdata   (reg_rdata)
    );

    assign hit = (ctrl_q.rise_en && |(rise & rmask)) ||
                 (ctrl_q.fall_en && |(fall & fmask));

    edge_irq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .ack_edge  (ack_edge),
        .ack_ovf   (ack_ovf),
        .edge_flag (edge_flag),
        .ovf_flag  (ovf_flag)
    );

    assign irq = ctrl_q.master_ie &&
                 ((edge_flag && ctrl_q.edge_ie) || (ovf_flag && ctrl_q.ovf_ie));

    assign status_byte = {{(REG_DW-3){1'b0}}, irq, ovf_flag, edge_flag};

endmodule

// File: rtl/edge_irq_chk.sv
module edge_irq_chk
    import edge_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              irq,
    input logic              edge_flag,
    input logic              ovf_flag,
    input logic              hit,
    input logic              master_ie,
    input logic [REG_AW-1:0] reg_addr,
    input logic              reg_wr,
    input logic [REG_DW-1:0] reg_wdata,
    input logic [REG_DW-1:0] reg_rdata
);

    AST_IRQ_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> master_ie) else $error("irq without master enable"); // R9

    AST_PENDING_MIRRORS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_STAT) |-> (reg_rdata[2] == irq)) else $error("pending bit differs from irq"); // R9

    AST_OVF_NEEDS_PRIOR_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(edge_flag) && $past(hit)) else $error("overflow without held edge"); // R7

    AST_EDGE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(edge_flag) |-> $past(hit)) else $error("edge flag without event"); // R4

    AST_ACK_CLEARS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_ACK && reg_wdata[ACK_EDGE_BIT] && !hit) |=> !edge_flag)
        else $error("edge flag survived acknowledge"); // R8

    AST_ACK_CLEARS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_ACK && reg_wdata[ACK_OVF_BIT] && !hit) |=> !ovf_flag)
        else $error("overflow flag survived acknowledge"); // R8

    AST_ID_CONSTANT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_ID) |-> (reg_rdata == ID_VALUE)) else $error("identification byte wrong"); // R2

endmodule

bind edge_irq_ctrl edge_irq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .edge_flag (edge_flag),
    .ovf_flag  (ovf_flag),
    .hit       (hit),
    .master_ie (ctrl_q.master_ie),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
);

// File: tb/edge_irq_ctrl_tb_top.sv
module edge_irq_ctrl_tb_top;

    localparam int NG  = 3;
    localparam int NCH = NG * 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] chan_in = '0;
    logic [7:0]     reg_addr = 8'h00;
    logic           reg_wr = 1'b0;
    logic [7:0]     reg_wdata = 8'h00;
    logic [7:0]     reg_rdata;
    logic           irq;

    always #2 clk = ~clk;

    edge_irq_ctrl #(.NUM_GROUPS(NG)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_in   (chan_in),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    typedef struct {
        string      tag;
        bit         is_irq;
        logic [7:0] exp;
    } item_t;

    item_t exp_q[$];
    item_t it;
    event  smp_ev;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(smp_ev);
            while (exp_q.size() > 0) begin
                it = exp_q.pop_front();
                n_cmp++;
                if (it.is_irq) begin
                    if (irq !== it.exp[0]) begin
                        n_bad++;
                        $display("FAIL %s irq actual=%0b expected=%0b", it.tag, irq, it.exp[0]);
                    end
                end else if (reg_rdata !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s rdata actual=%02h expected=%02h", it.tag, reg_rdata, it.exp);
                end
            end
        end
    end

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic expect_reg(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        exp_q.push_back('{tag, 1'b0, e});
        -> smp_ev;
        #1;
    endtask

    task automatic expect_irq(input bit e, input string tag);
        @(negedge clk);
        #1;
        exp_q.push_back('{tag, 1'b1, {7'b0, e}});
        -> smp_ev;
        #1;
    endtask

    // input change, then three edges: two sync stages and the state register
    task automatic drive_in(input logic [NCH-1:0] v);
        @(negedge clk);
        chan_in = v;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        expect_reg(8'h14, 8'h00, "R1 status");
        expect_reg(8'h15, 8'h00, "R1 control");
        expect_reg(8'h18, 8'h00, "R1 rmask0");
        expect_reg(8'h1A, 8'h00, "R1 rmask2");
        expect_reg(8'h21, 8'h00, "R1 fmask1");
        expect_irq(1'b0, "R1 irq");

        // identification
        expect_reg(8'h06, 8'h27, "R2 id");
        wr_reg(8'h06, 8'hFF);
        expect_reg(8'h06, 8'h27, "R2 id after write");

        // masks and control readback
        wr_reg(8'h19, 8'hA5);
        wr_reg(8'h22, 8'h3C);
        expect_reg(8'h19, 8'hA5, "R3 rmask1");
        expect_reg(8'h22, 8'h3C, "R3 fmask2");
        expect_reg(8'h18, 8'h00, "R3 rmask0 untouched");
        wr_reg(8'h15, 8'hFF);
        expect_reg(8'h15, 8'h1F, "R12 control readback");

        // ch0 rising enabled only
        wr_reg(8'h18, 8'h01);
        drive_in(24'h000002);
        expect_reg(8'h14, 8'h00, "R6 unmasked channel");
        drive_in(24'h000003);
        expect_reg(8'h14, 8'h05, "R4 rising edge ch0");
        expect_irq(1'b1, "R9 irq on edge");
        drive_in(24'h000103);
        expect_reg(8'h14, 8'h07, "R7 overflow ch8");

        // acknowledge
        wr_reg(8'h07, 8'h08);
        expect_reg(8'h14, 8'h06, "R8 clear edge only");
        wr_reg(8'h07, 8'h03);
        expect_reg(8'h14, 8'h06, "R8 other bits ignored");
        wr_reg(8'h07, 8'h04);
        expect_reg(8'h14, 8'h00, "R8 clear overflow");
        expect_irq(1'b0, "R8 irq after clear");

        // falling edge on ch1
        wr_reg(8'h20, 8'h02);
        drive_in(24'h000101);
        expect_reg(8'h14, 8'h05, "R5 falling edge ch1");
        wr_reg(8'h07, 8'h0C);
        expect_reg(8'h14, 8'h00, "R8 clear both");

        // falling gate off
        wr_reg(8'h15, 8'h0F);
        wr_reg(8'h20, 8'h03);
        drive_in(24'h000100);
        expect_reg(8'h14, 8'h00, "R6 falling gate off");

        // detection only, interrupts off
        wr_reg(8'h15, 8'h18);
        drive_in(24'h000101);
        expect_reg(8'h14, 8'h01, "R10 flag with irq off");
        expect_irq(1'b0, "R10 irq off");
        wr_reg(8'h15, 8'h1F);
        expect_irq(1'b1, "R9 irq after enable");
        wr_reg(8'h15, 8'h00);
        expect_irq(1'b0, "R10 irq after zero control");
        expect_reg(8'h14, 8'h01, "R10 flag kept");
        wr_reg(8'h15, 8'h06);
        expect_irq(1'b0, "R9 edge not enabled");
        expect_reg(8'h14, 8'h01, "R9 pending clear");
        wr_reg(8'h07, 8'h0C);

        // same-cycle event and acknowledge
        wr_reg(8'h15, 8'h0F);
        drive_in(24'h000100);
        wr_reg(8'h15, 8'h1F);
        drive_in(24'h000101);
        expect_reg(8'h14, 8'h05, "R11 setup edge");
        @(negedge clk);
        chan_in = 24'h000501;
        @(negedge clk);
        @(negedge clk);
        reg_addr  = 8'h07;
        reg_wdata = 8'h08;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
        expect_reg(8'h14, 8'h05, "R11 event wins, no overflow");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule